// File: doc/BRIEF.md
# Victim Line Write-Back Buffer

This block parks one dirty cache line that a cache miss has pushed out. The miss refill read can then use external memory first, and the write-back of the old line waits until that read is done. The cache hands over the whole victim line with its physical line address in a single load cycle. The buffer holds the line until it sees a refill-done (bus idle) pulse. It then writes the line out over a drain port as eight longword beats, each with a valid/ready handshake.

While the line is waiting or draining, a lookup port compares an incoming word address with the held line. On a match it returns the held longword, so a new read never sees stale memory contents.

The controller has three states:

- `ST_EMPTY`: no line is held.
- `ST_HELD`: a line is captured and the buffer waits for the refill.
- `ST_DRAIN`: beats are offered to memory.

It has four transitions:

- `T_LOAD`: `ST_EMPTY` to `ST_HELD` when a load is accepted.
- `T_RELEASE`: `ST_HELD` to `ST_DRAIN` on refill-done.
- `T_BEAT`: `ST_DRAIN` to `ST_DRAIN` when a beat other than the last is accepted.
- `T_FINISH`: `ST_DRAIN` to `ST_EMPTY` when the eighth beat is accepted.

Top module: `victim_wb_buffer`

## Requirements
- R1: After reset `ld_ready` is 1, `dr_valid` is 0 and `lk_hit` is 0.
- R2: A load (`ld_valid` high while `ld_ready` is high) is captured at the clock edge. From the next cycle on, `ld_ready` is 0 and `dr_valid` stays 0.
- R3: While a line is held and no refill-done has arrived, `dr_valid` stays 0. `dr_valid` becomes 1 in the cycle after the edge at which `refill_done` is sampled high.
- R4: Beats leave in order LW0 to LW7. Beat i carries `dr_data` = bits [32i+31:32i] of the loaded `ld_data`, and `dr_addr` = {line address, i[2:0], 2'b00}, a 29-bit byte address.
- R5: A beat advances only when `dr_valid` and `dr_ready` are both high at a clock edge. While `dr_ready` is low, `dr_addr` and `dr_data` hold their values.
- R6: `dr_last` is 1 only on the eighth beat. After that beat is accepted, the next cycle shows `dr_valid` at 0 and `ld_ready` at 1.
- R7: While a line is held or draining, `ld_ready` is 0 and a raised `ld_valid` has no effect on the line that drains.
- R8: `lk_hit` is 1 when `lk_valid` is high, a line is held or draining, and `lk_waddr[26:3]` (address bits [28:5]) equals the held line address. `lk_data` is then the held longword selected by `lk_waddr[2:0]`.
- R9: `lk_hit` is 0 when the buffer is empty or the line address does not match.
- R10: `refill_done` has no effect while the buffer is empty or draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Victim line offered by the cache |
| ld_ready | output | 1 | Buffer empty, load is taken |
| ld_line | input | 24 | Physical line address, address bits [28:5] |
| ld_data | input | 256 | Victim line, LW0 in bits [31:0] |
| refill_done | input | 1 | Refill read finished, bus free |
| dr_valid | output | 1 | Drain beat offered |
| dr_ready | input | 1 | Memory takes the beat |
| dr_addr | output | 29 | Byte address of the current beat |
| dr_data | output | 32 | Longword of the current beat |
| dr_last | output | 1 | Current beat is LW7 |
| lk_valid | input | 1 | Lookup request |
| lk_waddr | input | 27 | Lookup longword address, address bits [28:2] |
| lk_hit | output | 1 | Lookup targets the held line |
| lk_data | output | 32 | Held longword for the lookup |

## Verification
The assertions assume that the memory side treats `dr_ready` as a plain accept with no retraction rule. They also assume that `refill_done` is a single-cycle pulse whose meaning depends only on the current state. The stimulus drives every input on the falling edge and pulses `refill_done` for exactly one cycle. It uses random stall lengths on `dr_ready`, random hold times before the refill, and extra load and refill pulses in states where they must be ignored. Line addresses mix random values with the all-zero and all-one corners.

// File: rtl/vwb_pkg.sv
package vwb_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HELD  = 2'd1,
        ST_DRAIN = 2'd2
    } vwb_state_t;
endpackage

// File: rtl/vwb_ctrl.sv
module vwb_ctrl
    import vwb_pkg::*;
#(
    parameter int WORDS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_valid,
    input  logic                     refill_done,
    input  logic                     dr_ready,
    output logic                     ld_ready,
    output logic                     capture,
    output logic                     dr_valid,
    output logic                     dr_last,
    output logic                     busy,
    output logic [$clog2(WORDS)-1:0] beat_idx
);
    localparam int IDX_W = $clog2(WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    vwb_state_t state_q, state_d;
    logic [IDX_W-1:0] beat_q, beat_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    // transitions: T_LOAD, T_RELEASE, T_BEAT, T_FINISH
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_EMPTY: begin
                beat_d = '0;
                if (ld_valid) state_d = ST_HELD;
            end
            ST_HELD: begin
                if (refill_done) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (dr_ready) begin
                    if (beat_q == LAST_IDX) begin
                        state_d = ST_EMPTY;
                        beat_d  = '0;
                    end else begin
                        beat_d = beat_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        ld_ready = 1'b0;
        capture  = 1'b0;
        dr_valid = 1'b0;
        dr_last  = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_EMPTY: begin
                ld_ready = 1'b1;
                capture  = ld_valid;
                busy     = 1'b0;
            end
            ST_HELD: begin
            end
            ST_DRAIN: begin
                dr_valid = 1'b1;
                dr_last  = (beat_q == LAST_IDX);
            end
            default: busy = 1'b0;
        endcase
    end

    assign beat_idx = beat_q;
endmodule

// File: rtl/vwb_line_store.sv
module vwb_line_store #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 8,
    parameter int LINE_W = 24
) (
    input  logic                     clk,
    input  logic                     capture,
    input  logic [LINE_W-1:0]        in_line,
    input  logic [WORD_W*WORDS-1:0]  in_data,
    input  logic [$clog2(WORDS)-1:0] drain_idx,
    input  logic [$clog2(WORDS)-1:0] look_idx,
    output logic [LINE_W-1:0]        held_line,
    output logic [WORD_W-1:0]        drain_word,
    output logic [WORD_W-1:0]        look_word
);
    logic [WORDS-1:0][WORD_W-1:0] words_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (capture) line_q <= in_line;
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (capture) words_q[w] <= in_data[w*WORD_W +: WORD_W];
        end
    end

    assign held_line  = line_q;
    assign drain_word = words_q[drain_idx];
    assign look_word  = words_q[look_idx];
endmodule

// File: rtl/vwb_addr_match.sv
module vwb_addr_match #(
    parameter int LINE_W = 24
) (
    input  logic              busy,
    input  logic              lk_valid,
    input  logic [LINE_W-1:0] lk_line,
    input  logic [LINE_W-1:0] held_line,
    output logic              hit
);
    assign hit = busy && lk_valid && (lk_line == held_line);
endmodule

// File: rtl/victim_wb_buffer.sv
module victim_wb_buffer #(
    parameter int WORD_W  = 32,
    parameter int WORDS   = 8,
    parameter int PADDR_W = 29,
    localparam int BYTE_OFS = $clog2(WORD_W / 8),
    localparam int IDX_W    = $clog2(WORDS),
    localparam int LINE_OFS = BYTE_OFS + IDX_W,
    localparam int LINE_W   = PADDR_W - LINE_OFS,
    localparam int WADDR_W  = PADDR_W - BYTE_OFS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_valid,
    output logic                    ld_ready,
    input  logic [LINE_W-1:0]       ld_line,
    input  logic [WORD_W*WORDS-1:0] ld_data,
    input  logic                    refill_done,
    output logic                    dr_valid,
    input  logic                    dr_ready,
    output logic [PADDR_W-1:0]      dr_addr,
    output logic [WORD_W-1:0]       dr_data,
    output logic                    dr_last,
    input  logic                    lk_valid,
    input  logic [WADDR_W-1:0]      lk_waddr,
    output logic                    lk_hit,
    output logic [WORD_W-1:0]       lk_data
);
    logic             capture;
    logic             busy;
    logic [IDX_W-1:0] beat_idx;
    logic [LINE_W-1:0] held_line;

    vwb_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid    (ld_valid),
        .refill_done (refill_done),
        .dr_ready    (dr_ready),
        .ld_ready    (ld_ready),
        .capture     (capture),
        .dr_valid    (dr_valid),
        .dr_last     (dr_last),
        .busy        (busy),
        .beat_idx    (beat_idx)
    );

    vwb_line_store #(.WORD_W(WORD_W), .WORDS(WORDS), .LINE_W(LINE_W)) u_store (
        .clk        (clk),
        .capture    (capture),
        .in_line    (ld_line),
        .in_data    (ld_data),
        .drain_idx  (beat_idx),
        .look_idx   (lk_waddr[IDX_W-1:0]),
        .held_line  (held_line),
        .drain_word (dr_data),
        .look_word  (lk_data)
    );

    vwb_addr_match #(.LINE_W(LINE_W)) u_match (
        .busy      (busy),
        .lk_valid  (lk_valid),
        .lk_line   (lk_waddr[WADDR_W-1:IDX_W]),
        .held_line (held_line),
        .hit       (lk_hit)
    );

    assign dr_addr = {held_line, beat_idx, {BYTE_OFS{1'b0}}};
endmodule

// File: rtl/vwb_checker.sv
module vwb_checker #(
    parameter int WORD_W  = 32,
    parameter int PADDR_W = 29
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ld_valid,
    input logic               ld_ready,
    input logic               refill_done,
    input logic               dr_valid,
    input logic               dr_ready,
    input logic [PADDR_W-1:0] dr_addr,
    input logic [WORD_W-1:0]  dr_data,
    input logic               dr_last,
    input logic               lk_hit
);
    localparam int STEP = WORD_W / 8;

    assert_load_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |=> (!ld_ready && !dr_valid));

    assert_drain_after_refill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dr_valid) |-> $past(refill_done));

    assert_beat_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && dr_ready && !dr_last) |=> (dr_addr == $past(dr_addr) + PADDR_W'(STEP)));

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data)));

    assert_finish_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && dr_ready && dr_last) |=> (ld_ready && !dr_valid));

    assert_no_load_while_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_ready && dr_valid));

    assert_hit_only_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> !ld_ready);
endmodule

bind victim_wb_buffer vwb_checker #(.WORD_W(WORD_W), .PADDR_W(PADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_valid    (ld_valid),
    .ld_ready    (ld_ready),
    .refill_done (refill_done),
    .dr_valid    (dr_valid),
    .dr_ready    (dr_ready),
    .dr_addr     (dr_addr),
    .dr_data     (dr_data),
    .dr_last     (dr_last),
    .lk_hit      (lk_hit)
);

// File: tb/victim_wb_buffer_test.sv
`timescale 1ns/1ps
module victim_wb_buffer_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_valid = 1'b0;
    logic         ld_ready;
    logic [23:0]  ld_line = '0;
    logic [255:0] ld_data = '0;
    logic         refill_done = 1'b0;
    logic         dr_valid;
    logic         dr_ready = 1'b0;
    logic [28:0]  dr_addr;
    logic [31:0]  dr_data;
    logic         dr_last;
    logic         lk_valid = 1'b0;
    logic [26:0]  lk_waddr = '0;
    logic         lk_hit;
    logic [31:0]  lk_data;

    int total = 0;
    int bad = 0;
    int beats = 0;

    always #2.5 clk = ~clk;

    victim_wb_buffer uut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [255:0] d, input int i);
        return d[i*32 +: 32];
    endfunction

    function automatic logic [28:0] beat_addr(input logic [23:0] ln, input int i);
        return {ln, i[2:0], 2'b00};
    endfunction

    task automatic look(input logic [23:0] ln, input int i, input bit exp_hit, input logic [31:0] exp_d, input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_waddr = {ln, i[2:0]};
        #1;
        chk(lk_hit == exp_hit, req, 64'(lk_hit), 64'(exp_hit));
        if (exp_hit) chk(lk_data == exp_d, req, 64'(lk_data), 64'(exp_d));
        lk_valid = 1'b0;
    endtask

    task automatic run_line(input logic [23:0] ln, input logic [255:0] d);
        int hold;
        // R10: refill pulse while empty must not start anything
        @(negedge clk);
        refill_done = 1'b1;
        @(negedge clk);
        refill_done = 1'b0;
        chk(ld_ready == 1'b1 && dr_valid == 1'b0, "R10", {62'd0, ld_ready, dr_valid}, 64'h2);
        look(ln, 0, 1'b0, '0, "R9");
        // load
        @(negedge clk);
        ld_valid = 1'b1;
        ld_line  = ln;
        ld_data  = d;
        @(negedge clk);
        ld_valid = 1'b0;
        chk(ld_ready == 1'b0 && dr_valid == 1'b0, "R2", {62'd0, ld_ready, dr_valid}, 64'h0);
        // rogue load while held, R7
        ld_valid = 1'b1;
        ld_line  = ~ln;
        ld_data  = ~d;
        @(negedge clk);
        ld_valid = 1'b0;
        chk(ld_ready == 1'b0, "R7", 64'(ld_ready), 64'h0);
        hold = int'($urandom % 4);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk(dr_valid == 1'b0, "R3", 64'(dr_valid), 64'h0);
        end
        begin
            int wi = int'($urandom % 8);
            look(ln, wi, 1'b1, word_of(d, wi), "R8");
        end
        look(ln ^ 24'h1, 0, 1'b0, '0, "R9");
        // release
        @(negedge clk);
        chk(dr_valid == 1'b0, "R3", 64'(dr_valid), 64'h0);
        refill_done = 1'b1;
        @(negedge clk);
        refill_done = 1'b0;
        chk(dr_valid == 1'b1, "R3", 64'(dr_valid), 64'h1);
        // drain
        for (int i = 0; i < 8; i++) begin
            int st = int'($urandom % 3);
            for (int s = 0; s < st; s++) begin
                dr_ready = 1'b0;
                if (i == 3) refill_done = 1'b1;
                #1;
                chk(dr_valid && dr_addr == beat_addr(ln, i) && dr_data == word_of(d, i),
                    "R5", {3'd0, dr_addr, dr_data}, {3'd0, beat_addr(ln, i), word_of(d, i)});
                @(negedge clk);
                refill_done = 1'b0;
            end
            dr_ready = 1'b1;
            #1;
            chk(dr_valid == 1'b1, "R4", 64'(dr_valid), 64'h1);
            chk(dr_addr == beat_addr(ln, i), "R4", 64'(dr_addr), 64'(beat_addr(ln, i)));
            chk(dr_data == word_of(d, i), "R4", 64'(dr_data), 64'(word_of(d, i)));
            chk(dr_last == (i == 7), "R6", 64'(dr_last), 64'(i == 7));
            if (dr_valid) beats++;
            @(negedge clk);
        end
        dr_ready = 1'b0;
        #1;
        chk(ld_ready == 1'b1 && dr_valid == 1'b0, "R6", {62'd0, ld_ready, dr_valid}, 64'h2);
        look(ln, 2, 1'b0, '0, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lines;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(ld_ready == 1'b1 && dr_valid == 1'b0 && lk_hit == 1'b0, "R1",
            {61'd0, ld_ready, dr_valid, lk_hit}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ld_ready == 1'b1 && dr_valid == 1'b0, "R1", {62'd0, ld_ready, dr_valid}, 64'h2);
        lines = 0;
        run_line(24'h000000, {8{32'hA5A5_0000}} ^ {32'd7, 32'd6, 32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0});
        lines++;
        run_line(24'hFFFFFF, {8{32'hFFFF_FFFF}});
        lines++;
        for (int n = 0; n < 10; n++) begin
            logic [255:0] d;
            for (int w = 0; w < 8; w++) d[w*32 +: 32] = $urandom;
            run_line(24'($urandom), d);
            lines++;
        end
        chk(beats == lines * 8, "R6", 64'(beats), 64'(lines * 8));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule